// File: doc/BRIEF.md
# ATA Status and Device Control Block

This block holds the host-visible status byte of an ATA-style storage device and the write-only device control byte. Each cycle the internal controller offers its condition as level signals: busy, ready, write fault, seek complete, data request, corrected error and error. The block registers these into the status byte. The host reads that byte at two addresses. The primary status address also acknowledges a pending interrupt. The alternate address only observes it.

The internal controller raises an interrupt with a one-cycle pulse. The event stays pending until the host reads the primary status, until a hardware reset, or until a software reset. The interrupt pin shows the pending event unless the host has masked it through the control byte. The control byte is accepted at any time, even while the device reports busy. Through it the host holds the internal controller in software reset for as long as the reset bit stays set. After power-up, and after a software reset is released, the status reports busy and not ready until the controller first signals ready.

Top module: `ata_status_ctl`

## Requirements
- R1: After a synchronous reset, a status read returns 0x80, `host_irq` is 0 and `dev_srst` is 0.
- R2: Once the device is out of its busy-hold, the status byte reads as {busy, ready, fault, seek_done, drq, corr, 0, err}, from bit 7 down to bit 0. These are the event levels sampled at the previous clock edge. Bit 1 always reads 0.
- R3: After a hardware reset, the busy-hold lasts until `dev_ready` is first seen high. During the hold, bit 7 reads 1 and bits 6, 3 and 0 read 0.
- R4: A read of the primary status address clears the pending interrupt, so `host_irq` is 0 from the following cycle.
- R5: A read of the alternate status address returns the same byte as the primary address and leaves `host_irq` unchanged.
- R6: A `dev_irq_raise` pulse makes the interrupt pending. With interrupts enabled, `host_irq` is 1 from the following cycle.
- R7: Writing the control byte with bit 1 set masks `host_irq` without discarding the pending event. Clearing bit 1 exposes the event again.
- R8: Writes to the control byte take effect while busy is reported.
- R9: Writing the control byte with bit 2 set asserts `dev_srst`. It stays asserted until a control write with bit 2 clear.
- R10: While software reset is held, the pending interrupt is discarded. Status bit 7 reads 1 and bits 6, 3 and 0 read 0. After release, the busy-hold lasts until `dev_ready` is seen high.
- R11: A raise pulse in the same cycle as a primary status read leaves the interrupt pending.
- R12: A read at any other address returns 0 and keeps the pending interrupt. A write to the primary status address does not change the control byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_cs | input | 1 | Host chip select |
| host_addr | input | ADDR_W | Host register address |
| host_rd | input | 1 | Host read strobe, one access per cycle |
| host_wr | input | 1 | Host write strobe, one access per cycle |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Registered read data, valid the cycle after the strobe |
| host_irq | output | 1 | Host interrupt request |
| dev_busy | input | 1 | Controller busy level |
| dev_ready | input | 1 | Controller ready for a command |
| dev_fault | input | 1 | Write fault level |
| dev_seek_done | input | 1 | Seek complete level |
| dev_drq | input | 1 | Data request level |
| dev_corr | input | 1 | Corrected data error level |
| dev_err | input | 1 | Command ended in error |
| dev_irq_raise | input | 1 | One-cycle interrupt raise pulse |
| dev_srst | output | 1 | Software reset to the internal controller |

## Verification
The status layout is swept over all 128 combinations of the seven event inputs and read through the alternate address. A subset is read again at the primary address, which shows any bit slip or lane swap and any difference between the two addresses. Interrupt behaviour is exercised with several access patterns: a primary read, an alternate read, an unrelated-address read, a masked raise, a raise in the same cycle as a primary read, and a mask toggle while busy. Together these show which accesses clear, keep or hide the pending event. The software-reset sequence checks the forced status bits, interrupt discard, the hold of `dev_srst`, and the busy-hold after release with ready both low and high.

// File: rtl/ata_stat_pkg.sv
package ata_stat_pkg;
  localparam int DATA_W  = 8;
  localparam int ST_BUSY = 7;
  localparam int ST_RDY  = 6;
  localparam int ST_DWF  = 5;
  localparam int ST_DSC  = 4;
  localparam int ST_DRQ  = 3;
  localparam int ST_CORR = 2;
  localparam int ST_RSV  = 1;
  localparam int ST_ERR  = 0;
  localparam int DC_SRST = 2;
  localparam int DC_MASK = 1;
  localparam logic [DATA_W-1:0] STATUS_RST = 8'h80;

  typedef struct packed {
    logic busy;
    logic ready;
    logic fault;
    logic seek_done;
    logic drq;
    logic corr;
    logic err;
  } dev_evt_t;
endpackage

// File: rtl/ata_stat_reg.sv
module ata_stat_reg
  import ata_stat_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              srst,
  input  dev_evt_t          evt,
  output logic [DATA_W-1:0] stat_q
);
  logic hold_q, hold_d;
  logic [DATA_W-1:0] stat_d;

  // busy-hold: set by software reset, released by the first ready
  always_comb begin
    hold_d = srst | (hold_q & ~evt.ready);
    stat_d = '0;
    stat_d[ST_BUSY] = evt.busy | hold_d;
    stat_d[ST_RDY]  = evt.ready & ~hold_d;
    stat_d[ST_DWF]  = evt.fault;
    stat_d[ST_DSC]  = evt.seek_done;
    stat_d[ST_DRQ]  = evt.drq & ~hold_d;
    stat_d[ST_CORR] = evt.corr;
    stat_d[ST_ERR]  = evt.err & ~hold_d;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q <= 1'b1;
      stat_q <= STATUS_RST;
    end else begin
      hold_q <= hold_d;
      stat_q <= stat_d;
    end
  end
endmodule

// File: rtl/ata_devctl_reg.sv
module ata_devctl_reg
  import ata_stat_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  output logic              srst_q,
  output logic              mask_q,
  output logic              mask_d
);
  logic unused_wbits;
  assign unused_wbits = ^{wdata[DATA_W-1:DC_SRST+1], wdata[0]};

  assign mask_d = wr_en ? wdata[DC_MASK] : mask_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      srst_q <= 1'b0;
      mask_q <= 1'b0;
    end else if (wr_en) begin
      srst_q <= wdata[DC_SRST];
      mask_q <= wdata[DC_MASK];
    end
  end
endmodule

// File: rtl/ata_irq_ctl.sv
module ata_irq_ctl (
  input  logic clk,
  input  logic rst,
  input  logic raise,
  input  logic ack,
  input  logic srst,
  input  logic mask_d,
  output logic irq_q
);
  logic pend_q, pend_d;

  // software reset discards; a new raise beats a same-cycle acknowledge
  always_comb begin
    if (srst)       pend_d = 1'b0;
    else if (raise) pend_d = 1'b1;
    else if (ack)   pend_d = 1'b0;
    else            pend_d = pend_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      pend_q <= pend_d;
      irq_q  <= pend_d & ~mask_d;
    end
  end
endmodule

// File: rtl/ata_status_ctl.sv
module ata_status_ctl
  import ata_stat_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter logic [ADDR_W-1:0] STATUS_ADDR = 3'd7,
  parameter logic [ADDR_W-1:0] ALT_ADDR    = 3'd6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_cs,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic              host_rd,
  input  logic              host_wr,
  input  logic [DATA_W-1:0] host_wdata,
  output logic [DATA_W-1:0] host_rdata,
  output logic              host_irq,
  input  logic              dev_busy,
  input  logic              dev_ready,
  input  logic              dev_fault,
  input  logic              dev_seek_done,
  input  logic              dev_drq,
  input  logic              dev_corr,
  input  logic              dev_err,
  input  logic              dev_irq_raise,
  output logic              dev_srst
);
  logic st_rd, alt_rd, dc_wr;
  logic mask_q, mask_d;
  logic [DATA_W-1:0] stat_q;
  dev_evt_t evt;

  assign st_rd  = host_cs & host_rd & (host_addr == STATUS_ADDR);
  assign alt_rd = host_cs & host_rd & (host_addr == ALT_ADDR);
  assign dc_wr  = host_cs & host_wr & (host_addr == ALT_ADDR);

  assign evt = '{busy: dev_busy, ready: dev_ready, fault: dev_fault,
                 seek_done: dev_seek_done, drq: dev_drq, corr: dev_corr,
                 err: dev_err};

  ata_devctl_reg u_dc (
    .clk(clk), .rst(rst), .wr_en(dc_wr), .wdata(host_wdata),
    .srst_q(dev_srst), .mask_q(mask_q), .mask_d(mask_d)
  );

  ata_stat_reg u_st (
    .clk(clk), .rst(rst), .srst(dev_srst), .evt(evt), .stat_q(stat_q)
  );

  ata_irq_ctl u_irq (
    .clk(clk), .rst(rst), .raise(dev_irq_raise), .ack(st_rd),
    .srst(dev_srst), .mask_d(mask_d), .irq_q(host_irq)
  );

  logic unused_mask;
  assign unused_mask = mask_q;

  always_ff @(posedge clk) begin
    if (rst) host_rdata <= '0;
    else     host_rdata <= (st_rd | alt_rd) ? stat_q : '0;
  end
endmodule

// File: rtl/ata_status_ctl_chk.sv
module ata_status_ctl_chk #(
  parameter int ADDR_W = 3,
  parameter logic [ADDR_W-1:0] STATUS_ADDR = 3'd7,
  parameter logic [ADDR_W-1:0] ALT_ADDR    = 3'd6
) (
  input logic              clk,
  input logic              rst,
  input logic              host_cs,
  input logic [ADDR_W-1:0] host_addr,
  input logic              host_rd,
  input logic              host_wr,
  input logic              wd_srst,
  input logic              wd_mask,
  input logic [7:0]        host_rdata,
  input logic              host_irq,
  input logic              dev_irq_raise,
  input logic              dev_srst
);
  logic st_rd, alt_rd, dc_wr;
  assign st_rd  = host_cs && host_rd && host_addr == STATUS_ADDR;
  assign alt_rd = host_cs && host_rd && host_addr == ALT_ADDR;
  assign dc_wr  = host_cs && host_wr && host_addr == ALT_ADDR;

  p_rsv_zero_r2: assert property (@(posedge clk) disable iff (rst)
    host_rdata[1] == 1'b0);
  p_rd_clear_r4: assert property (@(posedge clk) disable iff (rst)
    (st_rd && !dev_irq_raise) |=> !host_irq);
  p_alt_keep_r5: assert property (@(posedge clk) disable iff (rst)
    (host_irq && alt_rd && !host_wr && !dev_srst) |=> host_irq);
  p_mask_r7: assert property (@(posedge clk) disable iff (rst)
    (dc_wr && wd_mask) |=> !host_irq);
  p_srst_set_r9: assert property (@(posedge clk) disable iff (rst)
    (dc_wr && wd_srst) |=> dev_srst);
  p_srst_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (dev_srst && !dc_wr) |=> dev_srst);
  p_srst_rel_r9: assert property (@(posedge clk) disable iff (rst)
    (dc_wr && !wd_srst) |=> !dev_srst);
  p_srst_irq_r10: assert property (@(posedge clk) disable iff (rst)
    dev_srst |=> !host_irq);
  p_srst_busy_r10: assert property (@(posedge clk) disable iff (rst)
    ($past(dev_srst) && dev_srst && (st_rd || alt_rd))
      |=> (host_rdata[7] && !host_rdata[6]));
endmodule

bind ata_status_ctl ata_status_ctl_chk #(
  .ADDR_W(ADDR_W), .STATUS_ADDR(STATUS_ADDR), .ALT_ADDR(ALT_ADDR)
) u_chk (
  .clk(clk), .rst(rst), .host_cs(host_cs), .host_addr(host_addr),
  .host_rd(host_rd), .host_wr(host_wr),
  .wd_srst(host_wdata[2]), .wd_mask(host_wdata[1]),
  .host_rdata(host_rdata), .host_irq(host_irq),
  .dev_irq_raise(dev_irq_raise), .dev_srst(dev_srst)
);

// File: tb/ata_status_ctl_test.sv
`timescale 1ns/1ps
module ata_status_ctl_test;
  localparam logic [2:0] A_ST  = 3'd7;
  localparam logic [2:0] A_ALT = 3'd6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic host_cs = 0, host_rd = 0, host_wr = 0;
  logic [2:0] host_addr = '0;
  logic [7:0] host_wdata = '0;
  logic [7:0] host_rdata;
  logic host_irq, dev_srst;
  logic dev_busy = 0, dev_ready = 0, dev_fault = 0, dev_seek_done = 0;
  logic dev_drq = 0, dev_corr = 0, dev_err = 0, dev_irq_raise = 0;

  int total = 0;
  int bad = 0;
  logic [7:0] got;

  always #10 clk = ~clk;

  ata_status_ctl uut (
    .clk(clk), .rst(rst), .host_cs(host_cs), .host_addr(host_addr),
    .host_rd(host_rd), .host_wr(host_wr), .host_wdata(host_wdata),
    .host_rdata(host_rdata), .host_irq(host_irq),
    .dev_busy(dev_busy), .dev_ready(dev_ready), .dev_fault(dev_fault),
    .dev_seek_done(dev_seek_done), .dev_drq(dev_drq), .dev_corr(dev_corr),
    .dev_err(dev_err), .dev_irq_raise(dev_irq_raise), .dev_srst(dev_srst)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: got 0x%02h expected 0x%02h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    host_cs = 1; host_rd = 1; host_addr = a;
    @(posedge clk); #1;
    d = host_rdata;
    @(negedge clk);
    host_cs = 0; host_rd = 0;
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    host_cs = 1; host_wr = 1; host_addr = a; host_wdata = d;
    @(posedge clk); #1;
    @(negedge clk);
    host_cs = 0; host_wr = 0; host_wdata = '0;
  endtask

  task automatic raise();
    @(negedge clk); dev_irq_raise = 1;
    @(negedge clk); dev_irq_raise = 0;
  endtask

  task automatic set_evt(input logic [6:0] v);
    @(negedge clk);
    {dev_busy, dev_ready, dev_fault, dev_seek_done, dev_drq, dev_corr, dev_err} = v;
    @(negedge clk);
  endtask

  initial begin
    #(20 * 200000);
    total++; bad++;
    $display("FAIL watchdog: got 0x00 expected 0x01");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 0;
    // R1
    rd(A_ST, got);
    check("R1 status", got, 8'h80);
    check("R1 irq", {7'd0, host_irq}, 8'h00);
    check("R1 srst", {7'd0, dev_srst}, 8'h00);
    // R3: hold masks drq/err while ready low
    set_evt(7'b0000101);
    rd(A_ALT, got);
    check("R3 hold", got, 8'h80);
    set_evt(7'b0100101);
    rd(A_ALT, got);
    check("R3 released", got, 8'h49);
    // R2 sweep over every event combination
    for (int i = 0; i < 128; i++) begin
      logic [6:0] v;
      v = 7'(i);
      set_evt(v);
      rd(A_ALT, got);
      check("R2 layout", got, {v[6:1], 1'b0, v[0]});
      if (i % 16 == 0) begin
        rd(A_ST, got);
        check("R5 same value", got, {v[6:1], 1'b0, v[0]});
      end
    end
    set_evt(7'b0101000);
    // R6, R5, R4
    raise();
    check("R6 irq", {7'd0, host_irq}, 8'h01);
    rd(A_ALT, got);
    check("R5 alt value", got, 8'h50);
    check("R5 irq kept", {7'd0, host_irq}, 8'h01);
    rd(A_ST, got);
    check("R4 value", got, 8'h50);
    check("R4 irq cleared", {7'd0, host_irq}, 8'h00);
    // R12
    raise();
    rd(3'd0, got);
    check("R12 other addr", got, 8'h00);
    check("R12 irq kept", {7'd0, host_irq}, 8'h01);
    wr(A_ST, 8'h06);
    check("R12 srst untouched", {7'd0, dev_srst}, 8'h00);
    check("R12 mask untouched", {7'd0, host_irq}, 8'h01);
    // R7
    wr(A_ALT, 8'h02);
    check("R7 masked", {7'd0, host_irq}, 8'h00);
    raise();
    check("R7 masked raise", {7'd0, host_irq}, 8'h00);
    wr(A_ALT, 8'h00);
    check("R7 unmasked", {7'd0, host_irq}, 8'h01);
    // R11
    @(negedge clk);
    host_cs = 1; host_rd = 1; host_addr = A_ST; dev_irq_raise = 1;
    @(posedge clk); #1;
    check("R11 raise wins", {7'd0, host_irq}, 8'h01);
    @(negedge clk);
    host_cs = 0; host_rd = 0; dev_irq_raise = 0;
    rd(A_ST, got);
    check("R4 clear after R11", {7'd0, host_irq}, 8'h00);
    // R8
    set_evt(7'b1101000);
    raise();
    wr(A_ALT, 8'h02);
    check("R8 mask while busy", {7'd0, host_irq}, 8'h00);
    wr(A_ALT, 8'h00);
    check("R8 unmask while busy", {7'd0, host_irq}, 8'h01);
    rd(A_ST, got);
    check("R8 busy visible", got, 8'hD0);
    set_evt(7'b0101000);
    // R9, R10
    raise();
    wr(A_ALT, 8'h04);
    check("R9 srst set", {7'd0, dev_srst}, 8'h01);
    repeat (2) @(negedge clk);
    check("R10 irq discarded", {7'd0, host_irq}, 8'h00);
    rd(A_ST, got);
    check("R10 forced status", got, 8'h90);
    repeat (5) @(negedge clk);
    check("R9 srst held", {7'd0, dev_srst}, 8'h01);
    set_evt(7'b0001000);
    wr(A_ALT, 8'h00);
    check("R9 srst released", {7'd0, dev_srst}, 8'h00);
    repeat (3) @(negedge clk);
    rd(A_ALT, got);
    check("R10 busy after release", got, 8'h90);
    set_evt(7'b0101000);
    rd(A_ALT, got);
    check("R10 ready after release", got, 8'h50);
    check("R10 no irq", {7'd0, host_irq}, 8'h00);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule